// File: doc/BRIEF.md
# Accumulator Execute Datapath

This block is the execute stage of a small 8-bit accumulator machine that uses 14-bit instruction words. It holds a working register W, a file of 128 eight-bit registers and a port B output register. The sequencer presents an instruction that has already been fetched, together with a valid strobe. On the next rising clock edge the block commits that instruction's result to W, to the addressed file register, or to port B.

The ALU result for the presented instruction is driven combinationally in every cycle, whether or not the strobe is high. Skip logic outside the block can test that result. The same path lets a caller read any file register, by presenting a move-file instruction with the strobe low. Flags, the program counter, the stack and skip sequencing belong to other blocks.

Top module: `acc_exec`

## Requirements
- R1: After an asynchronous active-low reset, W, port B and all 128 file registers read zero.
- R2: Literal operations take the immediate from bits [7:0] and always write W. Their bits [13:8] are:
  - 110000: load the immediate.
  - 111110: add the immediate to W.
  - 111000: OR with W.
  - 111001: AND with W.
  - 111010: XOR with W.
- R3: Both subtractions take W as the subtrahend. Literal subtract (bits [13:8] = 111100) gives immediate minus W. File subtract (000010) gives file minus W.
- R4: Byte file operations address the file with bits [6:0]. Bit 7 selects the destination: 0 sends the result to W and 1 writes it back to the file register. The operations, by bits [13:8], are:
  - 000111: add W to the file register.
  - 000101: AND with W.
  - 000100: OR with W.
  - 000110: XOR with W.
  - 001001: complement.
  - 000011: decrement.
  - 001010: increment.
  - 001000: move the file register.
- R5: Bits [13:8] = 000001 clear a location. With bit 7 set, the addressed file register is cleared. With bit 7 clear and bits [6:2] zero, W is cleared instead.
- R6: Bits [13:7] = 0000001 store W into the file register at bits [6:0]. When that address is 0x0D, the value goes to port B and file register 0x0D is left unchanged.
- R7: Bits [13:10] = 0100 clear one bit of the addressed file register and 0101 set one. Bits [9:7] give the bit index.
- R8: The shift, rotate and swap operations all obey the destination bit of R4. By bits [13:8] they are:
  - 110111: arithmetic shift right, keeping bit 7.
  - 110101: shift left, filling with 0.
  - 110110: logical shift right, filling with 0.
  - 001101: rotate left through bit 7.
  - 001100: rotate right through bit 0.
  - 001110: exchange the two nibbles.
- R9: State changes only at a rising clock edge on which the valid strobe is high.
- R10: Every other encoding leaves W, the file and port B unchanged. This includes all zeros. Two encodings still report a result without writing anything: 001011 reports the file register minus one, and 001111 reports the file register plus one.
- R11: alu_result always shows the result of the instruction currently presented, with the strobe high or low. For an encoding with no operation it shows the file register addressed by bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | High when instr is to be executed at the next edge |
| instr | input | 14 | Instruction word that has already been fetched |
| alu_result | output | 8 | Combinational result of the presented instruction |
| w_reg | output | 8 | Current value of W |
| port_b | output | 8 | Port B output register |

## Verification
Two pairs of actions can fall into the same cycle here.

The first is a combinational read of a file register together with the write-back to that register at the edge that ends the cycle. Random streams are confined to a narrow window of addresses, so consecutive read-modify-write instructions keep hitting the same entry. The bench checks both the result in the cycle and the value that a later read returns.

The second is the port B redirect against a file write at 0x0D. Directed stores to 0x0D are followed by reads of file register 0x0D, which must still hold its old value while port B takes W.

// File: rtl/acc_exec.sv
module acc_exec #(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int PORT_ADDR = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [13:0]   instr,
  output logic [DW-1:0] alu_result,
  output logic [DW-1:0] w_reg,
  output logic [DW-1:0] port_b
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] PB_ADDR = AW'(PORT_ADDR);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] regs [DEPTH];
  logic [DW-1:0] w_q, pb_q, f_val, lit, res, bmask;
  logic [AW-1:0] fa;
  logic [5:0]    op;
  logic          dst_f, byte_op, wr_w, wr_f, wr_pb;

  assign op     = instr[13:8];
  assign fa     = instr[AW-1:0];
  assign dst_f  = instr[7];
  assign lit    = instr[DW-1:0];
  assign f_val  = regs[fa];
  assign bmask  = ONE << instr[9:7];

  always_comb begin
    res = f_val;
    byte_op = 1'b0;
    wr_w = 1'b0;
    wr_f = 1'b0;
    wr_pb = 1'b0;
    casez (op)
      6'b110000: begin res = lit;          wr_w = 1'b1; end
      6'b111110: begin res = lit + w_q;    wr_w = 1'b1; end
      6'b111000: begin res = lit | w_q;    wr_w = 1'b1; end
      6'b111001: begin res = lit & w_q;    wr_w = 1'b1; end
      6'b111100: begin res = lit - w_q;    wr_w = 1'b1; end
      6'b111010: begin res = lit ^ w_q;    wr_w = 1'b1; end
      6'b000111: begin res = f_val + w_q;  byte_op = 1'b1; end
      6'b000101: begin res = f_val & w_q;  byte_op = 1'b1; end
      6'b000100: begin res = f_val | w_q;  byte_op = 1'b1; end
      6'b000110: begin res = f_val ^ w_q;  byte_op = 1'b1; end
      6'b000010: begin res = f_val - w_q;  byte_op = 1'b1; end
      6'b001001: begin res = ~f_val;       byte_op = 1'b1; end
      6'b000011: begin res = f_val - ONE;  byte_op = 1'b1; end
      6'b001010: begin res = f_val + ONE;  byte_op = 1'b1; end
      6'b001000: begin res = f_val;        byte_op = 1'b1; end
      6'b110111: begin res = {f_val[DW-1], f_val[DW-1:1]}; byte_op = 1'b1; end
      6'b110101: begin res = {f_val[DW-2:0], 1'b0};        byte_op = 1'b1; end
      6'b110110: begin res = {1'b0, f_val[DW-1:1]};        byte_op = 1'b1; end
      6'b001101: begin res = {f_val[DW-2:0], f_val[DW-1]}; byte_op = 1'b1; end
      6'b001100: begin res = {f_val[0], f_val[DW-1:1]};    byte_op = 1'b1; end
      6'b001110: begin res = {f_val[DW/2-1:0], f_val[DW-1:DW/2]}; byte_op = 1'b1; end
      6'b001011: res = f_val - ONE;
      6'b001111: res = f_val + ONE;
      6'b000001: begin
        if (dst_f) begin
          res = '0;
          wr_f = 1'b1;
        end else if (instr[6:2] == 5'b0) begin
          res = '0;
          wr_w = 1'b1;
        end
      end
      6'b000000: begin
        if (dst_f) begin
          res = w_q;
          wr_pb = (fa == PB_ADDR);
          wr_f = (fa != PB_ADDR);
        end
      end
      6'b0100??: begin res = f_val & ~bmask; wr_f = 1'b1; end
      6'b0101??: begin res = f_val | bmask;  wr_f = 1'b1; end
      default: ;
    endcase
    if (byte_op) begin
      wr_w = ~dst_f;
      wr_f = dst_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      pb_q <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (instr_valid) begin
      if (wr_w)  w_q <= res;
      if (wr_pb) pb_q <= res;
      if (wr_f)  regs[fa] <= res;
    end
  end

  assign alu_result = res;
  assign w_reg      = w_q;
  assign port_b     = pb_q;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int PORT_ADDR = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [13:0]   instr,
  input logic [DW-1:0] alu_result,
  input logic [DW-1:0] w_reg,
  input logic [DW-1:0] port_b
);
  localparam logic [AW-1:0] PB_ADDR = AW'(PORT_ADDR);

  logic pb_store, lit_op, byte_op, clrw_op;
  assign pb_store = instr_valid && instr[13:7] == 7'b0000001 && instr[AW-1:0] == PB_ADDR;
  assign lit_op   = instr_valid && instr[13:8] inside {6'b110000, 6'b111110, 6'b111000,
                                                       6'b111001, 6'b111100, 6'b111010};
  assign byte_op  = instr_valid && instr[13:8] inside {6'b000111, 6'b000101, 6'b000100,
                      6'b000110, 6'b000010, 6'b001001, 6'b000011, 6'b001010, 6'b001000,
                      6'b110111, 6'b110101, 6'b110110, 6'b001101, 6'b001100, 6'b001110};
  assign clrw_op  = instr_valid && instr[13:2] == 12'b000001000000;

  AST_IDLE_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(w_reg)); // R9
  AST_IDLE_PB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(port_b)); // R9
  AST_LIT_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
    lit_op |=> w_reg == $past(alu_result)); // R2
  AST_PB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pb_store |=> port_b == $past(w_reg)); // R6
  AST_PB_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_store |=> $stable(port_b)); // R6
  AST_FILE_DEST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_op && instr[7]) |=> $stable(w_reg)); // R4
  AST_W_DEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_op && !instr[7]) |=> w_reg == $past(alu_result)); // R4
  AST_CLRW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clrw_op |=> w_reg == '0); // R5
endmodule

bind acc_exec acc_exec_chk #(.DW(DW), .AW(AW), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .alu_result(alu_result), .w_reg(w_reg), .port_b(port_b)
);

// File: tb/tb_acc_exec.sv
module tb_acc_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  alu_result, w_reg, port_b;

  acc_exec dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .alu_result(alu_result), .w_reg(w_reg), .port_b(port_b)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 1'b0;
  logic [7:0] m_w = '0;
  logic [7:0] m_pb = '0;
  logic [7:0] m_f [128];

  localparam logic [5:0] OPS [27] = '{
    6'b110000, 6'b111110, 6'b111000, 6'b111001, 6'b111100, 6'b111010,
    6'b000111, 6'b000101, 6'b000100, 6'b000110, 6'b000010, 6'b001001,
    6'b000011, 6'b001010, 6'b001000, 6'b110111, 6'b110101, 6'b110110,
    6'b001101, 6'b001100, 6'b001110, 6'b000001, 6'b000000, 6'b001011,
    6'b001111, 6'b101000, 6'b110100};

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [13:0] ins);
    logic [5:0] op = ins[13:8];
    if (op == 6'b111100 || op == 6'b000010) return "R3";
    if (op inside {6'b110000, 6'b111110, 6'b111000, 6'b111001, 6'b111010}) return "R2";
    if (op inside {6'b110111, 6'b110101, 6'b110110, 6'b001101, 6'b001100, 6'b001110}) return "R8";
    if (op inside {6'b000111, 6'b000101, 6'b000100, 6'b000110, 6'b001001,
                   6'b000011, 6'b001010, 6'b001000}) return "R4";
    if (op == 6'b000001) return "R5";
    if (op == 6'b000000 && ins[7]) return "R6";
    if (ins[13:11] == 3'b010) return "R7";
    return "R10";
  endfunction

  task automatic model(input logic [13:0] ins, output logic [7:0] r,
                       output bit ww, output bit wf, output bit wp);
    logic [7:0] f = m_f[ins[6:0]];
    logic [7:0] k = ins[7:0];
    logic [7:0] bm = 8'd1 << ins[9:7];
    bit d = ins[7];
    bit bo = 1'b1;
    r = f; ww = 0; wf = 0; wp = 0;
    case (ins[13:8])
      6'b110000: begin r = k;     bo = 0; ww = 1; end
      6'b111110: begin r = k + m_w; bo = 0; ww = 1; end
      6'b111000: begin r = k | m_w; bo = 0; ww = 1; end
      6'b111001: begin r = k & m_w; bo = 0; ww = 1; end
      6'b111100: begin r = k - m_w; bo = 0; ww = 1; end
      6'b111010: begin r = k ^ m_w; bo = 0; ww = 1; end
      6'b000111: r = f + m_w;
      6'b000101: r = f & m_w;
      6'b000100: r = f | m_w;
      6'b000110: r = f ^ m_w;
      6'b000010: r = f - m_w;
      6'b001001: r = ~f;
      6'b000011: r = f - 8'd1;
      6'b001010: r = f + 8'd1;
      6'b001000: r = f;
      6'b110111: r = {f[7], f[7:1]};
      6'b110101: r = {f[6:0], 1'b0};
      6'b110110: r = {1'b0, f[7:1]};
      6'b001101: r = {f[6:0], f[7]};
      6'b001100: r = {f[0], f[7:1]};
      6'b001110: r = {f[3:0], f[7:4]};
      6'b001011: begin r = f - 8'd1; bo = 0; end
      6'b001111: begin r = f + 8'd1; bo = 0; end
      6'b000001: begin
        bo = 0;
        if (d) begin r = 0; wf = 1; end
        else if (ins[6:2] == 0) begin r = 0; ww = 1; end
      end
      6'b000000: begin
        bo = 0;
        if (d) begin
          r = m_w;
          if (ins[6:0] == 7'h0D) wp = 1; else wf = 1;
        end
      end
      default: begin
        bo = 0;
        if (ins[13:10] == 4'b0100) begin r = f & ~bm; wf = 1; end
        else if (ins[13:10] == 4'b0101) begin r = f | bm; wf = 1; end
      end
    endcase
    if (bo) begin ww = !d; wf = d; end
  endtask

  task automatic step(input logic [13:0] ins, input bit v, input string tag);
    logic [7:0] r;
    bit ww, wf, wp;
    @(negedge clk);
    instr = ins;
    instr_valid = v;
    #1;
    model(ins, r, ww, wf, wp);
    chk(alu_result, r, {tag, " alu_result R11"});
    @(posedge clk);
    #1;
    if (v) begin
      if (ww) m_w = r;
      if (wp) m_pb = r;
      if (wf) m_f[ins[6:0]] = r;
    end
    chk(w_reg, m_w, {tag, " w_reg"});
    chk(port_b, m_pb, {tag, " port_b"});
  endtask

  task automatic peek(input logic [6:0] a, input string tag);
    step({6'b001000, 1'b0, a}, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [13:0] ins;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) m_f[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(w_reg, 8'h00, "R1 reset w_reg");
    chk(port_b, 8'h00, "R1 reset port_b");
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) peek(7'(i), "R1 reset file");

    step(14'h305A, 1'b1, "R2 load");
    step(14'h3E10, 1'b1, "R2 add");
    step(14'h3C03, 1'b1, "R3 literal sub");
    step(14'h00A0, 1'b1, "R6 store 0x20");
    step(14'h3005, 1'b1, "R2 load");
    step(14'h0220, 1'b1, "R3 file sub to W");
    step(14'h00A0, 1'b1, "R6 store 0x20");
    step(14'h3081, 1'b1, "R2 load");
    step(14'h008D, 1'b1, "R6 store port");
    peek(7'h0D, "R6 file 0x0D untouched");
    step(14'h37A0, 1'b1, "R8 asr to file");
    step(14'h35A0, 1'b1, "R8 lsl to file");
    step(14'h0E20, 1'b1, "R8 swap to W");
    step(14'h01A0, 1'b1, "R5 clear file");
    peek(7'h20, "R5 cleared file");
    step(14'h0103, 1'b1, "R5 clear W");
    step(14'h17A0, 1'b1, "R7 set bit 7");
    step(14'h1020, 1'b1, "R7 clear bit 0");
    step(14'h13A0, 1'b1, "R7 clear bit 7");
    step(14'h30FF, 1'b0, "R9 idle load");
    step(14'h008D, 1'b0, "R9 idle store");
    step(14'h0000, 1'b1, "R10 nop");
    step(14'h2845, 1'b1, "R10 jump");
    step(14'h0F20, 1'b1, "R10 inc-test");
    peek(7'h20, "R10 inc-test no write");
    step(14'h0A20, 1'b1, "R4 inc to W");
    step(14'h0AA0, 1'b1, "R4 inc to file");

    for (int n = 0; n < 4000; n++) begin
      ins = 14'($urandom);
      if ($urandom_range(0, 5) != 0) ins[13:8] = OPS[$urandom_range(0, 26)];
      if ($urandom_range(0, 2) != 0) ins[6:0] = {4'b0001, 3'($urandom_range(0, 7))};
      step(ins, $urandom_range(0, 7) != 0, tag_of(ins));
      if (n % 16 == 0) peek(7'h0D, "R11 probe 0x0D");
    end
    for (int i = 8; i < 16; i++) peek(7'(i), "R11 final probe");
    finish_run();
  end
endmodule